// File: doc/BRIEF.md
# Command Slot Status Tracker

This block keeps the execution state of a single command slot. Software arms the slot by writing a control word with its start bit set. The slot then reads as busy until the execution engine reports an outcome. That outcome is one of three: a clean finish, a fault with a 20-bit cause vector, or a request that the operating system step in. On each accepted outcome the block captures the cause vector, a 4-bit substatus and a 7-bit execution-flag vector, and presents them as plain status pins and as a packed status doubleword.

A fault whose cause bits all lie inside a fixed set of transient causes is retried in hardware. The block pulses a retry request for one cycle and keeps the slot busy. It does this up to a programmable number of times, and after that it settles on the fault state. A fault that carries any cause bit outside that set settles at once. Every pin is a plain strobe or level. No streamed data passes through the block, so there is no back-pressure. Strobes are acted on in the cycle they are high.

Top module: `cmd_status_tracker`

## Requirements
- R1: Status codes are idle=0, fault=1, busy=2, os-call=3. After reset, status is idle and all captured fields, flags and counters are zero. `status_dw` carries status in bits 57:56 and substatus in bits 61:58, and every other bit is zero.
- R2: A write with `cmd_word[0]`=1 while status is not busy makes status busy on the next cycle. It also clears the cause, substatus, execution flags and retry count. A write with `cmd_word[0]`=0 changes nothing.
- R3: A completion strobe while busy captures cause, substatus and flags. Code 0 moves the slot to idle, and code 3 moves it to os-call. A completion with code 2 is ignored entirely.
- R4: A completion strobe while status is not busy changes nothing.
- R5: A start write while busy leaves every field unchanged. It sets `proto_err`, which stays set until reset.
- R6: `retryable` is 1 exactly when status is fault and the captured cause has no bit set outside the mask {7,8,9,12,14,17,18}.
- R7: Consider a completion with code 1 whose cause has no bit outside that mask. If fewer than `retry_limit` retries have been made since the last start, `retry_req` is high for one cycle, status stays busy and the retry count increments.
- R8: A code-1 completion that is not retried sets status to fault. This covers the case where the retry limit has been reached, including a limit of 0.
- R9: `mq_code` is substatus bits 2:0 (0 none, 1 buffer overflow, 2 queue limit, 3 page overflow, 4 atomic refused, 5 put refused). `abort_flag` is substatus bit 3. `exec_flags` shows the captured flag vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Control-word write strobe |
| cmd_word | input | 8 | Low control byte; bit 0 is start |
| retry_limit | input | 4 | Maximum hardware retries per command |
| done_vld | input | 1 | Completion strobe from the engine |
| done_code | input | 2 | Outcome code, encoded as in R1 |
| done_cause | input | 20 | Fault cause vector |
| done_sub | input | 4 | Substatus from the engine |
| done_exs | input | 7 | Execution-flag vector from the engine |
| status | output | 2 | Current status code |
| substatus | output | 4 | Captured substatus |
| cause | output | 20 | Captured cause vector |
| exec_flags | output | 7 | Captured execution flags |
| mq_code | output | 3 | Message-queue result field |
| abort_flag | output | 1 | Implicit-abort indication |
| retryable | output | 1 | Fault is of a transient kind |
| retry_req | output | 1 | One-cycle hardware retry request |
| proto_err | output | 1 | Sticky start-while-busy flag |
| status_dw | output | 64 | Packed status doubleword |

## Verification
The bench mixes transient cause bits with one hard bit and checks that the fault then lands at once. A design that tested only for any overlap with the mask would retry here instead. It runs a retry sequence until the limit is used up, and also uses a limit of zero. An off-by-one in the counter would show up as one retry too many or too few. It sends a start write while the slot is busy, a completion while idle and a completion with the busy code. A design that let any of these through would corrupt the captured fields or drop out of the busy state. It also checks that a fresh start clears the captured cause and substatus but leaves the protocol-error flag set.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FLT  = 2'd1,
    ST_BUSY = 2'd2,
    ST_OSC  = 2'd3
  } st_e;

  localparam int CAUSE_W = 20;
  localparam int SUB_W   = 4;
  localparam int EXS_W   = 7;
  localparam int LIM_W   = 4;
  localparam int DW_W    = 64;
  localparam int ST_LSB  = 56;
  localparam int MQ_W    = SUB_W - 1;

  // transient causes: bits 7,8,9,12,14,17,18
  localparam logic [CAUSE_W-1:0] SOFT_MASK = 20'h65380;
endpackage

// File: rtl/cst_cause_class.sv
module cst_cause_class #(
  parameter int W = 20,
  parameter logic [W-1:0] MASK = '0
) (
  input  logic [W-1:0] cause_in,
  output logic         soft_only
);
  logic [W-1:0] hard_bits;
  always_comb begin
    hard_bits = cause_in & ~MASK;
    soft_only = (hard_bits == '0);
  end
endmodule

// File: rtl/cst_retry_ctr.sv
module cst_retry_ctr #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [LW-1:0] limit,
  output logic          room
);
  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign room = (cnt < limit);

  assert_clear_zeroes_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/cmd_status_tracker.sv
module cmd_status_tracker
  import cst_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic [7:0]          cmd_word,
  input  logic [LIM_W-1:0]    retry_limit,
  input  logic                done_vld,
  input  logic [1:0]          done_code,
  input  logic [CAUSE_W-1:0]  done_cause,
  input  logic [SUB_W-1:0]    done_sub,
  input  logic [EXS_W-1:0]    done_exs,
  output logic [1:0]          status,
  output logic [SUB_W-1:0]    substatus,
  output logic [CAUSE_W-1:0]  cause,
  output logic [EXS_W-1:0]    exec_flags,
  output logic [MQ_W-1:0]     mq_code,
  output logic                abort_flag,
  output logic                retryable,
  output logic                retry_req,
  output logic                proto_err,
  output logic [DW_W-1:0]     status_dw
);
  st_e                 st_q;
  logic [CAUSE_W-1:0]  cause_q;
  logic [SUB_W-1:0]    sub_q;
  logic [EXS_W-1:0]    exs_q;
  logic                perr_q;
  logic                rreq_q;

  logic start_hit, take_start, take_done, busy;
  logic in_soft, held_soft, room, do_retry;
  st_e  code_e;

  always_comb begin
    busy       = (st_q == ST_BUSY);
    code_e     = st_e'(done_code);
    start_hit  = cmd_wr & cmd_word[0];
    take_start = start_hit & ~busy;
    take_done  = done_vld & busy & (code_e != ST_BUSY);
    do_retry   = take_done & (code_e == ST_FLT) & in_soft & room;
  end

  cst_cause_class #(.W(CAUSE_W), .MASK(SOFT_MASK)) u_cls_in (
    .cause_in (done_cause),
    .soft_only(in_soft)
  );

  cst_cause_class #(.W(CAUSE_W), .MASK(SOFT_MASK)) u_cls_held (
    .cause_in (cause_q),
    .soft_only(held_soft)
  );

  cst_retry_ctr #(.LW(LIM_W)) u_rctr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (take_start),
    .inc  (do_retry),
    .limit(retry_limit),
    .room (room)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cause_q <= '0;
      sub_q   <= '0;
      exs_q   <= '0;
      perr_q  <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      rreq_q <= do_retry;
      if (start_hit && busy) perr_q <= 1'b1;
      if (take_start) begin
        st_q    <= ST_BUSY;
        cause_q <= '0;
        sub_q   <= '0;
        exs_q   <= '0;
      end else if (take_done) begin
        cause_q <= done_cause;
        sub_q   <= done_sub;
        exs_q   <= done_exs;
        case (code_e)
          ST_IDLE: st_q <= ST_IDLE;
          ST_OSC:  st_q <= ST_OSC;
          default: st_q <= do_retry ? ST_BUSY : ST_FLT;
        endcase
      end
    end
  end

  always_comb begin
    status     = st_q;
    substatus  = sub_q;
    cause      = cause_q;
    exec_flags = exs_q;
    mq_code    = sub_q[MQ_W-1:0];
    abort_flag = sub_q[SUB_W-1];
    retryable  = (st_q == ST_FLT) & held_soft;
    retry_req  = rreq_q;
    proto_err  = perr_q;
    status_dw  = '0;
    status_dw[ST_LSB +: 2]         = st_q;
    status_dw[ST_LSB + 2 +: SUB_W] = sub_q;
  end

  assert_start_arms_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_word[0] && status != 2'd2) |=> (status == 2'd2 && cause == '0));

  assert_busy_start_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_word[0] && status == 2'd2 && !done_vld) |=> (proto_err && $stable(status)));

  assert_perr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  assert_idle_done_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && status != 2'd2 && !cmd_wr) |=> ($stable(status) && $stable(cause)));

  assert_retry_keeps_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> (status == 2'd2));

  assert_retryable_only_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retryable |-> (status == 2'd1));
endmodule

// File: tb/cmd_status_tracker_bench.sv
`timescale 1ns/1ps
module cmd_status_tracker_bench;
  localparam logic [19:0] MASK = 20'h65380;
  localparam int VW = 104;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [7:0]  cmd_word = '0;
  logic [3:0]  retry_limit = '0;
  logic        done_vld = 1'b0;
  logic [1:0]  done_code = '0;
  logic [19:0] done_cause = '0;
  logic [3:0]  done_sub = '0;
  logic [6:0]  done_exs = '0;
  logic [1:0]  status;
  logic [3:0]  substatus;
  logic [19:0] cause;
  logic [6:0]  exec_flags;
  logic [2:0]  mq_code;
  logic        abort_flag, retryable, retry_req, proto_err;
  logic [63:0] status_dw;

  cmd_status_tracker u_cmd_status_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .retry_limit(retry_limit), .done_vld(done_vld), .done_code(done_code),
    .done_cause(done_cause), .done_sub(done_sub), .done_exs(done_exs),
    .status(status), .substatus(substatus), .cause(cause),
    .exec_flags(exec_flags), .mq_code(mq_code), .abort_flag(abort_flag),
    .retryable(retryable), .retry_req(retry_req), .proto_err(proto_err),
    .status_dw(status_dw)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [VW-1:0] exp_q[$];
  string         tag_q[$];

  // reference state
  logic [1:0]  ms = 2'd0;
  logic [19:0] mc = '0;
  logic [3:0]  msub = '0;
  logic [6:0]  mx = '0;
  logic        mperr = 1'b0;
  logic        mrq = 1'b0;
  int          mcnt = 0;

  function automatic logic [VW-1:0] actual_vec();
    return {status, substatus, cause, exec_flags, retryable, retry_req,
            proto_err, mq_code, abort_flag, status_dw};
  endfunction

  function automatic logic [VW-1:0] model_vec();
    logic [63:0] dw;
    logic        rt;
    dw = '0;
    dw[57:56] = ms;
    dw[61:58] = msub;
    rt = (ms == 2'd1) && ((mc & ~MASK) == '0);
    return {ms, msub, mc, mx, rt, mrq, mperr, msub[2:0], msub[3], dw};
  endfunction

  task automatic op(input logic wr, input logic [7:0] word, input logic dv,
                    input logic [1:0] code, input logic [19:0] cs,
                    input logic [3:0] sb, input logic [6:0] ex,
                    input logic [3:0] lim, input string tag);
    logic hit;
    @(negedge clk);
    cmd_wr = wr; cmd_word = word; done_vld = dv; done_code = code;
    done_cause = cs; done_sub = sb; done_exs = ex; retry_limit = lim;
    @(posedge clk);
    #1;
    cmd_wr = 1'b0; done_vld = 1'b0;
    hit = wr & word[0];
    mrq = 1'b0;
    if (hit && ms == 2'd2) mperr = 1'b1;
    if (hit && ms != 2'd2) begin
      ms = 2'd2; mc = '0; msub = '0; mx = '0; mcnt = 0;
    end else if (dv && ms == 2'd2 && code != 2'd2) begin
      mc = cs; msub = sb; mx = ex;
      if (code == 2'd0) ms = 2'd0;
      else if (code == 2'd3) ms = 2'd3;
      else if (((cs & ~MASK) == '0) && (mcnt < int'(lim))) begin
        mcnt++; mrq = 1'b1;
      end else ms = 2'd1;
    end
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [VW-1:0] e;
        logic [VW-1:0] a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = actual_vec();
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, a, e);
        end
      end
    end
  end

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (actual_vec() !== model_vec()) begin
      errors++;
      $display("FAIL R1 reset: actual %h expected %h", actual_vec(), model_vec());
    end
    op(1, 8'hFE, 0, 0, 0, 0, 0, 0, "R2 start bit clear ignored");
    op(1, 8'h01, 0, 0, 0, 0, 0, 0, "R2 start arms slot R1 packing");
    op(1, 8'h01, 0, 0, 0, 0, 0, 0, "R5 start while busy");
    op(0, 0, 1, 2'd0, 20'h00400, 4'h3, 7'h24, 0, "R3 clean finish capture");
    op(0, 0, 1, 2'd1, 20'h00200, 4'h1, 7'h11, 0, "R4 completion while idle");
    op(1, 8'h03, 0, 0, 0, 0, 0, 0, "R2 restart clears fields R5 sticky");
    op(0, 0, 1, 2'd3, 20'h00001, 4'h2, 7'h08, 0, "R3 os-call outcome");
    op(1, 8'h01, 0, 0, 0, 0, 0, 2, "R2 restart");
    op(0, 0, 1, 2'd1, 20'h00200, 4'h0, 7'h20, 2, "R7 first retry");
    op(0, 0, 1, 2'd1, 20'h40080, 4'h0, 7'h20, 2, "R7 second retry");
    op(0, 0, 1, 2'd1, 20'h00200, 4'h0, 7'h20, 2, "R8 limit used R6 retryable");
    op(1, 8'h01, 0, 0, 0, 0, 0, 2, "R2 restart");
    op(0, 0, 1, 2'd1, 20'h00201, 4'h0, 7'h20, 2, "R6 hard bit no retry");
    op(1, 8'h01, 0, 0, 0, 0, 0, 0, "R2 restart");
    op(0, 0, 1, 2'd2, 20'h00002, 4'h5, 7'h04, 0, "R3 busy code ignored");
    op(0, 0, 1, 2'd1, 20'h40000, 4'hD, 7'h41, 0, "R8 zero limit R9 substatus view");
    op(1, 8'h01, 0, 0, 0, 0, 0, 1, "R2 restart");
    op(0, 0, 1, 2'd1, 20'h05000, 4'hC, 7'h7F, 1, "R7 retry with limit one");
    op(0, 0, 1, 2'd1, 20'h80000, 4'h4, 7'h01, 1, "R6 forced cause fatal R9");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule